// File: doc/BRIEF.md
# Quirk-Configurable Register ALU

This block is the register-to-register arithmetic and logic unit of a small 8-bit interpreter processor with sixteen general registers. It contains the 16 x 8 register file. For each start pulse it reads the register selected by index X and the register selected by index Y. It applies the operation chosen by a 4-bit selector and writes the result back to register X. It also updates the last register, which serves as the flag register.

A set of behaviour switches ("quirks") changes two things. The first is whether the bitwise operations clear the flag register. The second is which operand a shift reads. A 2-bit mode input selects one of three fixed quirk presets, or takes both switches directly from two input pins. The rest of the processor reads and writes the registers through a plain single-register port.

The flag write is applied after the result write. When X names the flag register, the flag value is what remains there. One operation is completed per start pulse, and a done strobe follows one cycle later.

Top module: `qalu_top`

## Requirements
- R1: On `op` code 0 the unit copies VY into VX and leaves the flag register (register 15) unchanged.
- R2: Codes 1, 2 and 3 write VX OR VY, VX AND VY and VX XOR VY into VX.
- R3: After codes 1, 2 and 3, the flag register is cleared to 0 when the keep-flag quirk is 0. It is left unchanged when that quirk is 1.
- R4: Code 4 writes (VX + VY) mod 256 into VX, and sets the flag register to 1 on a carry out of bit 7 or to 0 otherwise.
- R5: Code 5 writes VX - VY and code 7 writes VY - VX, both mod 256. The flag register becomes 1 when the minuend is greater than or equal to the subtrahend (no borrow), else 0.
- R6: Code 6 writes src >> 1 and sets the flag register to src bit 0. Code 14 (hex E) writes (src << 1) mod 256 and sets the flag register to src bit 7. src is VX when the shift-from-X quirk is 1 and VY when it is 0.
- R7: `mode` selects the quirks as {keep-flag, shift-from-X}:
  - 0 gives {0,0}.
  - 1 gives {1,1}.
  - 2 gives {1,0}.
  - 3 takes `quirk_keep_flag` and `quirk_shift_x` from the pins.
- R8: When X is 15 and the operation writes the flag, register 15 ends with the flag value and not the result. When the operation leaves the flag alone, register 15 takes the result.
- R9: Codes 8 to 13 and 15 change no register. They raise `illegal` together with `done`.
- R10: `done` is high for exactly the one cycle that follows a cycle with `start` high. At that point the new register values can already be read on `reg_rdata`.
- R11: Synchronous active-high `rst` clears all sixteen registers, `done` and `illegal` to 0.
- R12: `reg_we` writes `reg_wdata` into register `reg_addr` at the clock edge. If an operation writes the same register at the same edge, the operation's value wins. `reg_rdata` always shows register `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute one operation at this edge |
| op | input | 4 | Operation selector |
| idx_x | input | 4 | Destination and first operand register index |
| idx_y | input | 4 | Second operand register index |
| mode | input | 2 | Quirk preset select |
| quirk_keep_flag | input | 1 | Keep-flag switch used when mode is 3 |
| quirk_shift_x | input | 1 | Shift-from-X switch used when mode is 3 |
| reg_we | input | 1 | External register write enable |
| reg_addr | input | 4 | External register index for read and write |
| reg_wdata | input | 8 | External write data |
| reg_rdata | output | 8 | Contents of register reg_addr |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Unrecognised operation code, valid with done |

## Verification
The bench aims first at the flag register as a destination. A design that writes the result after the flag would leave the sum or difference in register 15 instead of the carry or borrow bit. It checks subtraction at the equal-operand boundary: a design that used a strict comparison would report a borrow for equal values. It checks addition exactly at the 8-bit wrap. It walks through all four modes and compares the shift source and the logic flag side effect. A wrong preset table would show up as a shift of the wrong register or a flag that is cleared when it should be kept. It also sends unlisted codes, and an external write aimed at the register the operation writes. A decoder with a default write path, or the wrong write priority, would then corrupt a register.

// File: rtl/qalu_pkg.sv
package qalu_pkg;

   typedef struct packed {
      logic keep_flag;   // bitwise ops leave the flag register untouched
      logic shift_x;     // shifts read VX instead of VY
   } quirk_t;

   typedef enum logic [1:0] {
      MODE_CLASSIC  = 2'd0,
      MODE_EXTENDED = 2'd1,
      MODE_HYBRID   = 2'd2,
      MODE_CUSTOM   = 2'd3
   } mode_e;

   localparam logic [3:0] OP_COPY  = 4'h0;
   localparam logic [3:0] OP_OR    = 4'h1;
   localparam logic [3:0] OP_AND   = 4'h2;
   localparam logic [3:0] OP_XOR   = 4'h3;
   localparam logic [3:0] OP_ADD   = 4'h4;
   localparam logic [3:0] OP_SUBXY = 4'h5;
   localparam logic [3:0] OP_SHR   = 4'h6;
   localparam logic [3:0] OP_SUBYX = 4'h7;
   localparam logic [3:0] OP_SHL   = 4'hE;

   function automatic quirk_t preset_quirks(input mode_e m, input quirk_t pins);
      quirk_t q;
      unique case (m)
         MODE_CLASSIC:  q = '{keep_flag: 1'b0, shift_x: 1'b0};
         MODE_EXTENDED: q = '{keep_flag: 1'b1, shift_x: 1'b1};
         MODE_HYBRID:   q = '{keep_flag: 1'b1, shift_x: 1'b0};
         default:       q = pins;
      endcase
      return q;
   endfunction

endpackage

// File: rtl/qalu_quirk_sel.sv
module qalu_quirk_sel
   import qalu_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       pin_keep_flag,
   input  logic       pin_shift_x,
   output quirk_t     quirks
);
   quirk_t pins;
   assign pins   = '{keep_flag: pin_keep_flag, shift_x: pin_shift_x};
   assign quirks = preset_quirks(mode_e'(mode), pins);

   // R7: preset table rows fixed by mode
   always_comb begin
      if (mode == 2'd0) a_r7_classic: assert (quirks == 2'b00);
      if (mode == 2'd1) a_r7_extended: assert (quirks == 2'b11);
      if (mode == 2'd2) a_r7_hybrid: assert (quirks == 2'b10);
   end
endmodule

// File: rtl/qalu_exec.sv
module qalu_exec
   import qalu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] vx,
   input  logic [DATA_W-1:0] vy,
   input  quirk_t            quirks,
   output logic [DATA_W-1:0] res,
   output logic              res_we,
   output logic [DATA_W-1:0] flag,
   output logic              flag_we,
   output logic              bad_op
);
   localparam logic [DATA_W-1:0] ZERO = '0;

   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] src;

   assign sum = {1'b0, vx} + {1'b0, vy};
   assign src = quirks.shift_x ? vx : vy;

   function automatic logic [DATA_W-1:0] as_flag(input logic b);
      return {{(DATA_W-1){1'b0}}, b};
   endfunction

   always_comb begin
      res     = ZERO;
      res_we  = 1'b1;
      flag    = ZERO;
      flag_we = 1'b0;
      bad_op  = 1'b0;
      unique case (op)
         OP_COPY: res = vy;
         OP_OR: begin
            res     = vx | vy;
            flag_we = ~quirks.keep_flag;
         end
         OP_AND: begin
            res     = vx & vy;
            flag_we = ~quirks.keep_flag;
         end
         OP_XOR: begin
            res     = vx ^ vy;
            flag_we = ~quirks.keep_flag;
         end
         OP_ADD: begin
            res     = sum[DATA_W-1:0];
            flag    = as_flag(sum[DATA_W]);
            flag_we = 1'b1;
         end
         OP_SUBXY: begin
            res     = vx - vy;
            flag    = as_flag(vx >= vy);
            flag_we = 1'b1;
         end
         OP_SUBYX: begin
            res     = vy - vx;
            flag    = as_flag(vy >= vx);
            flag_we = 1'b1;
         end
         OP_SHR: begin
            res     = src >> 1;
            flag    = as_flag(src[0]);
            flag_we = 1'b1;
         end
         OP_SHL: begin
            res     = src << 1;
            flag    = as_flag(src[DATA_W-1]);
            flag_we = 1'b1;
         end
         default: begin
            res_we = 1'b0;
            bad_op = 1'b1;
         end
      endcase
   end

   // R9: an unlisted code requests no write of any kind
   always_comb begin
      if (bad_op) a_r9_no_write: assert (!res_we && !flag_we);
   end
endmodule

// File: rtl/qalu_regfile.sv
module qalu_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 16,
   localparam int AW    = $clog2(NREG),
   localparam int FLAG_IDX = NREG - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [AW-1:0]     rx_addr,
   output logic [DATA_W-1:0] rx_data,
   input  logic [AW-1:0]     ry_addr,
   output logic [DATA_W-1:0] ry_data,
   input  logic [AW-1:0]     ext_addr,
   output logic [DATA_W-1:0] ext_rdata,
   input  logic              ext_we,
   input  logic [DATA_W-1:0] ext_wdata,
   input  logic              res_we,
   input  logic [AW-1:0]     res_addr,
   input  logic [DATA_W-1:0] res_data,
   input  logic              flag_we,
   input  logic [DATA_W-1:0] flag_data,
   output logic [DATA_W-1:0] flag_q
);
   logic [NREG-1:0][DATA_W-1:0] regs;

   // Write priority per register: flag, then result, then external port.
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic hit_res, hit_ext, hit_flag;
      assign hit_flag = flag_we && (g == FLAG_IDX);
      assign hit_res  = res_we && (res_addr == AW'(g));
      assign hit_ext  = ext_we && (ext_addr == AW'(g));
      always_ff @(posedge clk) begin
         if (rst)           regs[g] <= '0;
         else if (hit_flag) regs[g] <= flag_data;
         else if (hit_res)  regs[g] <= res_data;
         else if (hit_ext)  regs[g] <= ext_wdata;
      end
   end

   assign rx_data   = regs[rx_addr];
   assign ry_data   = regs[ry_addr];
   assign ext_rdata = regs[ext_addr];
   assign flag_q    = regs[FLAG_IDX];

   // R11: reset empties the file
   a_r11_reset_clear: assert property (@(posedge clk)
      rst |=> (regs == '0));

   // R12: an uncontested external write lands
   a_r12_ext_write: assert property (@(posedge clk) disable iff (rst)
      (ext_we && !(res_we && res_addr == ext_addr)
              && !(flag_we && ext_addr == AW'(FLAG_IDX)))
      |=> regs[$past(ext_addr)] == $past(ext_wdata));

   // R8: flag value wins over the result on the flag register
   a_r8_flag_wins: assert property (@(posedge clk) disable iff (rst)
      (flag_we && res_we && res_addr == AW'(FLAG_IDX)) |=> flag_q == $past(flag_data));
endmodule

// File: rtl/qalu_top.sv
module qalu_top
   import qalu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NREG   = 16,
   localparam int AW    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic [AW-1:0]     idx_x,
   input  logic [AW-1:0]     idx_y,
   input  logic [1:0]        mode,
   input  logic              quirk_keep_flag,
   input  logic              quirk_shift_x,
   input  logic              reg_we,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              done,
   output logic              illegal
);
   if (DATA_W < 2) begin : g_bad_width
      $error("qalu_top: DATA_W must be at least 2");
   end
   if (NREG != 16) begin : g_bad_depth
      $error("qalu_top: NREG must be 16 to match 4-bit register indices");
   end

   quirk_t            quirks;
   logic [DATA_W-1:0] vx, vy, res, flag, flag_q;
   logic              res_we, flag_we, bad_op;

   qalu_quirk_sel u_quirks (
      .mode          (mode),
      .pin_keep_flag (quirk_keep_flag),
      .pin_shift_x   (quirk_shift_x),
      .quirks        (quirks)
   );

   qalu_exec #(.DATA_W(DATA_W)) u_exec (
      .op      (op),
      .vx      (vx),
      .vy      (vy),
      .quirks  (quirks),
      .res     (res),
      .res_we  (res_we),
      .flag    (flag),
      .flag_we (flag_we),
      .bad_op  (bad_op)
   );

   qalu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk       (clk),
      .rst       (rst),
      .rx_addr   (idx_x),
      .rx_data   (vx),
      .ry_addr   (idx_y),
      .ry_data   (vy),
      .ext_addr  (reg_addr),
      .ext_rdata (reg_rdata),
      .ext_we    (reg_we),
      .ext_wdata (reg_wdata),
      .res_we    (start && res_we),
      .res_addr  (idx_x),
      .res_data  (res),
      .flag_we   (start && flag_we),
      .flag_data (flag),
      .flag_q    (flag_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done    <= 1'b0;
         illegal <= 1'b0;
      end else begin
         done    <= start;
         illegal <= start && bad_op;
      end
   end

   // R10: strobe follows start by one cycle only
   a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
      start |=> done);
   a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
      !start |=> !done);
   // R9: unlisted code reported with done and flag register held
   a_r9_illegal_flag: assert property (@(posedge clk) disable iff (rst)
      (start && op inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hF} && !reg_we)
      |=> illegal && done && $stable(flag_q));
   // R3: logic op with keep-flag off leaves zero in the flag register
   a_r3_logic_clears: assert property (@(posedge clk) disable iff (rst)
      (start && op inside {4'h1, 4'h2, 4'h3} && !quirks.keep_flag) |=> flag_q == '0);
   // R4: carry of the addition reaches the flag register
   a_r4_add_carry: assert property (@(posedge clk) disable iff (rst)
      (start && op == 4'h4) |=> flag_q[0] == $past(({1'b0, vx} + {1'b0, vy}) >> DATA_W));
endmodule

// File: tb/qalu_top_test.sv
`timescale 1ns/1ps
module qalu_top_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [3:0] op = '0, idx_x = '0, idx_y = '0;
   logic [1:0] mode = '0;
   logic       quirk_keep_flag = 1'b0, quirk_shift_x = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       done, illegal;

   int checks = 0, failures = 0;
   logic [7:0] m [16];
   bit finished = 0;

   always #2.5 clk = ~clk;

   qalu_top uut (
      .clk(clk), .rst(rst), .start(start), .op(op), .idx_x(idx_x), .idx_y(idx_y),
      .mode(mode), .quirk_keep_flag(quirk_keep_flag), .quirk_shift_x(quirk_shift_x),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .done(done), .illegal(illegal)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < 16; i++) begin
         reg_addr = 4'(i);
         #0.1;
         check(req, reg_rdata, m[i]);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      m[a] = d;
   endtask

   // Model of quirk presets (R7): returns {keep_flag, shift_x}
   function automatic logic [1:0] mq();
      case (mode)
         2'd0: return 2'b00;
         2'd1: return 2'b11;
         2'd2: return 2'b10;
         default: return {quirk_keep_flag, quirk_shift_x};
      endcase
   endfunction

   task automatic run_op(input logic [3:0] o, input logic [3:0] x, input logic [3:0] y,
                         input string req);
      logic [7:0] a, b, s, r, f;
      logic [8:0] t;
      logic wf, wr_en, bad;
      logic [1:0] q;
      q = mq();
      a = m[x]; b = m[y]; s = q[0] ? a : b;
      wr_en = 1; wf = 0; f = 0; bad = 0; r = 0;
      case (o)
         4'h0: r = b;
         4'h1: begin r = a | b; wf = !q[1]; end
         4'h2: begin r = a & b; wf = !q[1]; end
         4'h3: begin r = a ^ b; wf = !q[1]; end
         4'h4: begin t = a + b; r = t[7:0]; f = {7'd0, t[8]}; wf = 1; end
         4'h5: begin r = a - b; f = (a < b) ? 8'd0 : 8'd1; wf = 1; end
         4'h7: begin r = b - a; f = (b < a) ? 8'd0 : 8'd1; wf = 1; end
         4'h6: begin r = {1'b0, s[7:1]}; f = {7'd0, s[0]}; wf = 1; end
         4'hE: begin r = {s[6:0], 1'b0}; f = {7'd0, s[7]}; wf = 1; end
         default: begin wr_en = 0; bad = 1; end
      endcase
      @(negedge clk);
      start = 1'b1; op = o; idx_x = x; idx_y = y;
      @(negedge clk);
      start = 1'b0;
      check({req, " done"}, {7'd0, done}, 8'd1);
      check({req, " illegal"}, {7'd0, illegal}, {7'd0, bad});
      if (wr_en) m[x] = r;
      if (wf) m[15] = f;
      check_all(req);
      @(negedge clk);
      check({req, " R10 done drops"}, {7'd0, done}, 8'd0);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 16; i++) m[i] = 8'h00;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R11 done", {7'd0, done}, 8'd0);
      check("R11 illegal", {7'd0, illegal}, 8'd0);
      check_all("R11 regs");
   endtask

   task automatic t_copy_logic();
      mode = 2'd0;
      wr(4'd1, 8'hA5); wr(4'd2, 8'h3C); wr(4'd15, 8'h77);
      run_op(4'h0, 4'd3, 4'd1, "R1 copy");
      run_op(4'h1, 4'd1, 4'd2, "R2 or");
      wr(4'd1, 8'hA5);
      run_op(4'h2, 4'd1, 4'd2, "R2 and");
      wr(4'd1, 8'hA5); wr(4'd15, 8'h55);
      run_op(4'h3, 4'd1, 4'd2, "R2 xor R3 clear");
      mode = 2'd2; wr(4'd15, 8'h42);
      run_op(4'h1, 4'd4, 4'd2, "R3 keep");
   endtask

   task automatic t_arith();
      mode = 2'd0;
      wr(4'd5, 8'hFF); wr(4'd6, 8'h01);
      run_op(4'h4, 4'd5, 4'd6, "R4 add wrap carry");
      wr(4'd5, 8'h7F);
      run_op(4'h4, 4'd5, 4'd6, "R4 add no carry");
      wr(4'd5, 8'h20); wr(4'd6, 8'h20);
      run_op(4'h5, 4'd5, 4'd6, "R5 sub equal");
      wr(4'd5, 8'h10); wr(4'd6, 8'h20);
      run_op(4'h5, 4'd5, 4'd6, "R5 sub borrow");
      wr(4'd5, 8'h10); wr(4'd6, 8'h20);
      run_op(4'h7, 4'd5, 4'd6, "R5 rsub no borrow");
      run_op(4'h7, 4'd6, 4'd5, "R5 rsub borrow");
   endtask

   task automatic t_shift();
      for (int md = 0; md < 4; md++) begin
         mode = 2'(md);
         quirk_keep_flag = 1'b0; quirk_shift_x = 1'b1;
         wr(4'd7, 8'h81); wr(4'd8, 8'h42);
         run_op(4'h6, 4'd7, 4'd8, "R6 R7 shr");
         wr(4'd7, 8'h81); wr(4'd8, 8'h42);
         run_op(4'hE, 4'd7, 4'd8, "R6 R7 shl");
         wr(4'd15, 8'h33);
         run_op(4'h2, 4'd9, 4'd8, "R7 logic flag");
      end
      mode = 2'd3; quirk_keep_flag = 1'b1; quirk_shift_x = 1'b0;
      wr(4'd15, 8'h11);
      run_op(4'h3, 4'd9, 4'd8, "R7 custom keep");
   endtask

   task automatic t_flag_dest();
      mode = 2'd0;
      wr(4'd15, 8'hF0); wr(4'd1, 8'h20);
      run_op(4'h4, 4'd15, 4'd1, "R8 add into flag reg");
      wr(4'd15, 8'h05); wr(4'd1, 8'h03);
      run_op(4'h5, 4'd15, 4'd1, "R8 sub into flag reg");
      mode = 2'd1; wr(4'd15, 8'h0C); wr(4'd1, 8'h30);
      run_op(4'h1, 4'd15, 4'd1, "R8 or keeps result");
   endtask

   task automatic t_illegal();
      mode = 2'd0;
      foreach (m[i]) ;
      run_op(4'h8, 4'd1, 4'd2, "R9 code8");
      run_op(4'hC, 4'd15, 4'd2, "R9 codeC");
      run_op(4'hF, 4'd3, 4'd4, "R9 codeF");
   endtask

   task automatic t_ext_port();
      mode = 2'd0;
      wr(4'd3, 8'h10); wr(4'd4, 8'h05);
      @(negedge clk);
      start = 1'b1; op = 4'h4; idx_x = 4'd3; idx_y = 4'd4;
      reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 8'hEE;
      @(negedge clk);
      start = 1'b0; reg_we = 1'b0;
      m[3] = 8'h15; m[15] = 8'h00;
      check_all("R12 collision op wins");
      @(negedge clk);
      start = 1'b1; op = 4'h0; idx_x = 4'd3; idx_y = 4'd4;
      reg_we = 1'b1; reg_addr = 4'd10; reg_wdata = 8'h9A;
      @(negedge clk);
      start = 1'b0; reg_we = 1'b0;
      m[3] = 8'h05; m[10] = 8'h9A;
      check_all("R12 both land");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_copy_logic();
      t_arith();
      t_shift();
      t_flag_dest();
      t_illegal();
      t_ext_port();
      t_reset();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule